// File: doc/BRIEF.md
# Phased Three-Tap Averaging FIR

This block is a sampled low-pass FIR filter of length three. Every tap carries the weight one quarter, so the output is the sum of the three most recent samples divided by four. The delay line does not shift in one clock. A sequencer counts enabled master ticks in frames of eight. At three fixed ticks of each frame it raises a one-tick strobe, and each strobe moves one stage.

The oldest stage moves first and the newest stage moves last. The middle sample is copied into the oldest tap, then the newest sample is copied into the middle tap, and last the input sample is captured into the newest tap. Because of this order, no sample is overwritten before it has moved on. The valid pulse comes in the tick after all three moves, so the averaged result is read only when the taps hold one consistent set of samples.

The block advances only on clock edges where the master-tick enable is high. The tap values and the phase strobes are brought out so that the sequence can be observed.

Top module: `fir3_phased_avg`

## Requirements
- R1: `y_o` equals floor((tap0 + tap1 + tap2) / 4), computed on signed two's-complement taps at two bits above the sample width, with truncation toward negative infinity. For example, samples -2048, -2048 and -1 give -1025.
- R2: A frame is eight enabled master ticks, numbered 0 to 7. After tick 7 the sequence returns to tick 0 and repeats.
- R3: Only ticks 0, 2 and 4 raise a strobe: `cp0_o` at tick 0, `cp1_o` at tick 2 and `cp2_o` at tick 4. At the other five ticks all strobes are low.
- R4: An enabled tick with `cp0_o` high copies the middle tap (`tap1_o`) into the oldest tap (`tap2_o`).
- R5: An enabled tick with `cp1_o` high copies the newest tap (`tap0_o`) into the middle tap.
- R6: An enabled tick with `cp2_o` high loads `x_i` into the newest tap.
- R7: `y_valid_o` is high only at tick 5, after all three moves of the frame are complete.
- R8: Reset clears all taps and the tick counter to zero. `cp0_o` is therefore high right after reset, and `y_o` is 0.
- R9: While `tick_i` is low, the tick counter, the taps and the strobes hold their values.
- R10: `x_i` has no effect on the taps except at an enabled tick where `cp2_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Master-tick enable |
| x_i | input | DATA_W | Signed input sample |
| tap0_o | output | DATA_W | Newest tap |
| tap1_o | output | DATA_W | Middle tap |
| tap2_o | output | DATA_W | Oldest tap |
| y_o | output | DATA_W | Averaged result |
| y_valid_o | output | 1 | Result valid, high at tick 5 |
| cp0_o | output | 1 | Strobe that moves the oldest stage |
| cp1_o | output | 1 | Strobe that moves the middle stage |
| cp2_o | output | 1 | Strobe that captures the input sample |

## Verification
The bench changes `x_i` at every tick except the capture tick. A design that captures at the wrong phase, or that shifts in the wrong order, therefore shows a repeated sample or a wrong sample in the taps at tick 5.

Runs of full-scale positive samples and full-scale negative samples expose a sum that is too narrow, which would wrap the result. A negative sum that is not a multiple of four exposes rounding toward zero where flooring is required.

One test stalls the enable while the input is at the capture tick. A design that advances without the enable would move its strobes or load the changed input during the stall. A reset in the middle of a frame must leave zero taps and the first strobe raised.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  localparam int NUM_TAPS    = 3;
  localparam int GUARD_W     = 2;                     // sum headroom for 3 taps
  localparam int AVG_SHIFT   = 2;                     // weight 1/4
  localparam int STB_SPACING = 2;
  localparam int VALID_SLOT  = STB_SPACING * (NUM_TAPS - 1) + 1;

  // stage i (0 = newest) strobes at slot STB_SPACING*(NUM_TAPS-1-i): oldest first
  function automatic int stage_slot(input int stage);
    return STB_SPACING * (NUM_TAPS - 1 - stage);
  endfunction
endpackage

// File: rtl/fir3_phase_seq.sv
module fir3_phase_seq
  import fir3_pkg::*;
#(
  parameter int FRAME_TICKS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  output logic [NUM_TAPS-1:0] stb_o,
  output logic                valid_o
);
  localparam int CNT_W = $clog2(FRAME_TICKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_stb
    assign stb_o[i] = (cnt_q == CNT_W'(stage_slot(i)));
  end

  assign valid_o = (cnt_q == CNT_W'(VALID_SLOT));

  a_r2_frame_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == LAST) |=> (cnt_q == '0));
  a_r9_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/fir3_tap_line.sv
module fir3_tap_line
  import fir3_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             tick_i,
  input  logic [NUM_TAPS-1:0]              stb_i,
  input  logic signed [DATA_W-1:0]         x_i,
  output logic [NUM_TAPS-1:0][DATA_W-1:0]  taps_o
);
  logic [NUM_TAPS-1:0][DATA_W-1:0] tap_q;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  tap_q[i] <= '0;
        else if (tick_i && stb_i[i])  tap_q[i] <= x_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  tap_q[i] <= '0;
        else if (tick_i && stb_i[i])  tap_q[i] <= tap_q[i-1];
      end
    end
  end

  assign taps_o = tap_q;

  a_r4_old_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && stb_i[2]) |=> (tap_q[2] == $past(tap_q[1])));
  a_r5_mid_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && stb_i[1]) |=> (tap_q[1] == $past(tap_q[0])));
  a_r6_new_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && stb_i[0]) |=> (tap_q[0] == $past(x_i)));
  a_r9_taps_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tap_q));
endmodule

// File: rtl/fir3_avg.sv
module fir3_avg
  import fir3_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [NUM_TAPS-1:0][DATA_W-1:0] taps_i,
  output logic signed [DATA_W-1:0]        y_o
);
  localparam int SUM_W = DATA_W + GUARD_W;

  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] shifted;

  always_comb begin
    sum = '0;
    for (int i = 0; i < NUM_TAPS; i++)
      sum = sum + SUM_W'(signed'(taps_i[i]));
    shifted = sum >>> AVG_SHIFT;   // floor
  end

  assign y_o = shifted[DATA_W-1:0];
endmodule

// File: rtl/fir3_phased_avg.sv
module fir3_phased_avg
  import fir3_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int FRAME_TICKS = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic signed [DATA_W-1:0] x_i,
  output logic signed [DATA_W-1:0] tap0_o,
  output logic signed [DATA_W-1:0] tap1_o,
  output logic signed [DATA_W-1:0] tap2_o,
  output logic signed [DATA_W-1:0] y_o,
  output logic                     y_valid_o,
  output logic                     cp0_o,
  output logic                     cp1_o,
  output logic                     cp2_o
);
  logic [NUM_TAPS-1:0]             stb;
  logic [NUM_TAPS-1:0][DATA_W-1:0] taps;

  fir3_phase_seq #(.FRAME_TICKS(FRAME_TICKS)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .stb_o  (stb),
    .valid_o(y_valid_o)
  );

  fir3_tap_line #(.DATA_W(DATA_W)) i_taps (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .stb_i (stb),
    .x_i   (x_i),
    .taps_o(taps)
  );

  fir3_avg #(.DATA_W(DATA_W)) i_avg (
    .taps_i(taps),
    .y_o   (y_o)
  );

  assign tap0_o = taps[0];
  assign tap1_o = taps[1];
  assign tap2_o = taps[2];
  assign cp0_o  = stb[2];
  assign cp1_o  = stb[1];
  assign cp2_o  = stb[0];

  a_r7_valid_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cp2_o) |=> y_valid_o);
endmodule

// File: tb/test_fir3_phased_avg.sv
module test_fir3_phased_avg;
  localparam int DATA_W = 12;
  localparam int NS = 12;
  localparam logic signed [DATA_W-1:0] SAMPLES [NS] = '{
    12'sd100, 12'sd200, -12'sd300, 12'sd2047, 12'sd2047, 12'sd2047,
    -12'sd2048, -12'sd2048, -12'sd2048, -12'sd1, 12'sd0, 12'sd5};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic signed [DATA_W-1:0] x_i = '0;
  logic signed [DATA_W-1:0] tap0, tap1, tap2, y;
  logic y_valid, cp0, cp1, cp2;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int m0 = 0, m1 = 0, m2 = 0;

  always #4 clk = ~clk;

  fir3_phased_avg #(.DATA_W(DATA_W)) i_fir3_phased_avg (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .x_i(x_i),
    .tap0_o(tap0), .tap1_o(tap1), .tap2_o(tap2), .y_o(y),
    .y_valid_o(y_valid), .cp0_o(cp0), .cp1_o(cp1), .cp2_o(cp2));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int favg(input int a, input int b, input int c);
    int s;
    s = a + b + c;
    return s >>> 2;
  endfunction

  task automatic check_frame_point(input int t);
    chk(cp0 == (t == 0), "R3 cp0", cp0, t == 0);
    chk(cp1 == (t == 2), "R3 cp1", cp1, t == 2);
    chk(cp2 == (t == 4), "R3 cp2", cp2, t == 4);
    chk(y_valid == (t == 5), "R7 valid", y_valid, t == 5);
    if (t == 5) begin
      chk(int'(tap0) == m0, "R6/R10 tap0", tap0, m0);
      chk(int'(tap1) == m1, "R5 tap1", tap1, m1);
      chk(int'(tap2) == m2, "R4 tap2", tap2, m2);
      chk(int'(y) == favg(m0, m1, m2), "R1 result", y, favg(m0, m1, m2));
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    @(negedge clk);
    chk(tap0 == 0 && tap1 == 0 && tap2 == 0, "R8 taps", tap0, 0);
    chk(cp0 == 1'b1, "R8 cp0", cp0, 1);
    chk(y == 0 && !y_valid, "R8 y", y, 0);
    rst_ni = 1'b1;

    // R2 frames from table; x_i differs from the sample except at tick 4 (R10)
    for (int f = 0; f < NS; f++) begin
      for (int t = 0; t < 8; t++) begin
        @(negedge clk);
        tick_i = 1'b1;
        x_i = (t == 4) ? SAMPLES[f] : ~SAMPLES[f] + DATA_W'(t);
        if (t == 5) begin
          m2 = m1; m1 = m0; m0 = int'(SAMPLES[f]);
        end
        if (t == 4) chk(int'(tap0) == m0, "R10 tap0 before load", tap0, m0);
        check_frame_point(t);
      end
    end

    // R9 stall at the capture tick with a changing input
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      tick_i = 1'b1; x_i = 12'sd33;
      check_frame_point(t);
    end
    @(negedge clk);
    tick_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      x_i = 12'sd700 + DATA_W'(k);
      @(negedge clk);
      chk(cp2 && !cp0 && !cp1 && !y_valid, "R9 strobes held", cp2, 1);
      chk(int'(tap0) == m0, "R9 tap0 held", tap0, m0);
    end
    tick_i = 1'b1; x_i = 12'sd777;
    m2 = m1; m1 = m0; m0 = 777;
    @(negedge clk);
    check_frame_point(5);
    for (int t = 6; t < 8; t++) begin
      @(negedge clk);
      check_frame_point(t);
    end
    @(negedge clk);
    chk(cp0 == 1'b1, "R2 wrap to tick 0", cp0, 1);

    // R8 reset in mid frame
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(tap0 == 0 && tap1 == 0 && tap2 == 0, "R8 mid-frame taps", tap0, 0);
    chk(cp0 && !cp1 && !cp2, "R8 mid-frame cp0", cp0, 1);
    chk(y == 0, "R8 mid-frame y", y, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule